// File: doc/BRIEF.md
# Two-Wire Configuration Slave with Shadowed Nonvolatile Copy

This block is the configuration port of a programmable clock generator. It is a slave on a two-wire serial bus. Its inputs are the bus clock and data lines, which it samples with the system clock. It holds a small register file that sets the prescaler word, the 10-bit frequency code, the range offset and the device's own bus address. Every register has two copies. The working copy drives the generator outputs. The nonvolatile copy is modelled as a register array with a fixed programming time, and the working copy is reloaded from it on every power cycle.

A control bit chooses between two commit policies. With the bit clear, each accepted data byte is copied into the nonvolatile array at once. With the bit set, writes change only the working copy until the master writes a pointer byte that carries the commit command, which copies the whole working image in one step. The identity register always commits immediately. While the nonvolatile array is busy programming, the slave refuses every byte with a not-acknowledge, and it does not store a refused byte.

Top module: `clkgen_cfg_slave`

## Requirements
- R1: START (data falls while clock is high) begins an address phase from any state. A repeated START restarts the address phase and keeps the register pointer. STOP (data rises while clock is high) ends the transfer and releases the data line.
- R2: The 7-bit slave address is binary 1011 followed by identity register bits 2:0. Bit 0 of the address byte selects read (1) or write (0). A byte carrying any other address is not acknowledged, and the slave then leaves the data line released.
- R3: In a write, the address byte is followed by a pointer byte and then by data bytes, each acknowledged. The pointer advances by one per data byte. The map is: 02h/03h prescaler high/low byte; 08h/09h frequency code, with the 10-bit code equal to {08h[7:0], 09h[7:6]} and 09h bits 5:0 reading 0; 0Dh identity (bit 3 commit mode, bits 2:0 address select, bits 7:4 read 0); 0Eh offset (bits 4:0, bits 7:5 read 0). Any other location reads 00h and ignores writes.
- R4: With commit mode 1, data writes change only the working copy. A power cycle (rst_n low) then restores the previous nonvolatile values.
- R5: With commit mode 0, each accepted data byte is written to the nonvolatile copy and survives a power cycle. Each such write makes the array busy for NV_BUSY_CYCLES clock cycles.
- R6: A write to the identity register (0Dh) is committed to the nonvolatile copy even when commit mode is 1. The new address select takes effect for the next transfer.
- R7: A pointer byte of 3Fh in a write copies the entire working image into the nonvolatile copy.
- R8: While the array is busy, every received byte (address, pointer or data) is not acknowledged and has no effect.
- R9: In a read, bytes come from the pointer onward and the pointer advances after each byte. A master acknowledge requests another byte. A master not-acknowledge ends the read with the data line released. The slave changes the data line only while the clock is low.
- R10: nv_init_n loads the factory image into the nonvolatile copy: prescaler 0000h, frequency code DAC_DEFAULT, identity 0 and offset equal to RANGE_CODE. rst_n reloads the working copy from the nonvolatile copy.
- R11: Location 37h reads the factory RANGE_CODE in bits 4:0. A write to it is acknowledged and has no effect.
- R12: presc_word, dac_code and offset_code always show the working copy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| nv_init_n | input | 1 | Synchronous, active low: loads the factory image into the nonvolatile copy |
| rst_n | input | 1 | Synchronous, active low power cycle: reloads the working copy and resets the bus logic |
| scl_i | input | 1 | Bus clock line |
| sda_i | input | 1 | Bus data line as seen on the wire |
| sda_oe | output | 1 | 1 pulls the data line low (open drain) |
| presc_word | output | 16 | Working prescaler word {02h, 03h} |
| dac_code | output | 10 | Working 10-bit frequency code |
| offset_code | output | 5 | Working range offset |

## Verification
The bench goes after the places where the two commit policies meet. It sends a second byte in write-through mode while the array is still busy. A design that ignored the busy state would acknowledge that byte and store it. It writes in shadow mode and then power-cycles. A design that committed every write would keep the shadow value, and one that never reloaded would keep it too. It rewrites the identity register in shadow mode. A design that lost the immediate commit would answer at the old address after a power cycle. The bench also writes the read-only location and checks the masked bits of the left-justified code. Random multi-byte writes and readbacks across the pointer range then catch pointer-increment and masking errors.

// File: rtl/cfgs_pkg.sv
package cfgs_pkg;
  localparam int NREG = 6;
  localparam int IDXW = $clog2(NREG);

  localparam logic [3:0] DEV_ID     = 4'b1011;
  localparam logic [7:0] PTR_PRE_HI = 8'h02;
  localparam logic [7:0] PTR_PRE_LO = 8'h03;
  localparam logic [7:0] PTR_DAC_HI = 8'h08;
  localparam logic [7:0] PTR_DAC_LO = 8'h09;
  localparam logic [7:0] PTR_IDENT  = 8'h0D;
  localparam logic [7:0] PTR_OFS    = 8'h0E;
  localparam logic [7:0] PTR_RANGE  = 8'h37;
  localparam logic [7:0] PTR_COMMIT = 8'h3F;
  localparam int         IX_IDENT   = 4;

  typedef logic [NREG-1:0][7:0] img_t;

  typedef struct packed {
    logic            hit;
    logic [IDXW-1:0] idx;
  } slot_t;

  typedef enum logic [2:0] {ST_IDLE, ST_RX, ST_RX_ACK, ST_TX, ST_TX_ACK} bus_st_e;
  typedef enum logic [1:0] {K_ADDR, K_PTR, K_DATA} rx_kind_e;

  // Map a bus pointer onto a storage slot.
  function automatic slot_t slot_of(input logic [7:0] p);
    slot_t s;
    s.hit = 1'b1;
    case (p)
      PTR_PRE_HI: s.idx = IDXW'(0);
      PTR_PRE_LO: s.idx = IDXW'(1);
      PTR_DAC_HI: s.idx = IDXW'(2);
      PTR_DAC_LO: s.idx = IDXW'(3);
      PTR_IDENT:  s.idx = IDXW'(4);
      PTR_OFS:    s.idx = IDXW'(5);
      default: begin s.hit = 1'b0; s.idx = '0; end
    endcase
    return s;
  endfunction

  // Bits that exist in each slot.
  function automatic logic [7:0] byte_mask(input logic [IDXW-1:0] ix);
    case (ix)
      IDXW'(3): return 8'hC0;
      IDXW'(4): return 8'h0F;
      IDXW'(5): return 8'h1F;
      default:  return 8'hFF;
    endcase
  endfunction

  // Left-justified 10-bit code held in two bytes.
  function automatic logic [9:0] dac_code_of(input logic [7:0] hi, input logic [7:0] lo);
    return {hi, lo[7:6]};
  endfunction

  function automatic img_t factory_image(input logic [15:0] presc, input logic [9:0] dac,
                                         input logic [3:0] ident, input logic [4:0] rng);
    img_t f;
    f[0] = presc[15:8];
    f[1] = presc[7:0];
    f[2] = dac[9:2];
    f[3] = {dac[1:0], 6'b0};
    f[4] = {4'b0, ident};
    f[5] = {3'b0, rng};
    return f;
  endfunction
endpackage

// File: rtl/cfgs_line_sync.sv
module cfgs_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [STAGES-1:0] scl_p, sda_p;
  logic scl_q, sda_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      scl_p <= '1;
      sda_p <= '1;
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_p <= {scl_p[STAGES-2:0], scl_i};
      sda_p <= {sda_p[STAGES-2:0], sda_i};
      scl_q <= scl_p[STAGES-1];
      sda_q <= sda_p[STAGES-1];
    end
  end

  assign scl_s     = scl_p[STAGES-1];
  assign sda_s     = sda_p[STAGES-1];
  assign scl_rise  = scl_s & ~scl_q;
  assign scl_fall  = ~scl_s & scl_q;
  assign start_det = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/cfgs_nv_store.sv
module cfgs_nv_store import cfgs_pkg::*; #(
  parameter int   BUSY_CYC = 1000,
  parameter img_t FACTORY  = '0
) (
  input  logic            clk,
  input  logic            nv_init_n,
  input  logic            byte_we,
  input  logic [IDXW-1:0] byte_idx,
  input  logic [7:0]      byte_d,
  input  logic            bulk_we,
  input  img_t            bulk_d,
  output img_t            nv_img,
  output logic            busy
);
  localparam int CW = $clog2(BUSY_CYC + 1);
  logic [CW-1:0] remain;

  always_ff @(posedge clk) begin
    if (!nv_init_n) begin
      nv_img <= FACTORY;
      remain <= '0;
    end else begin
      if (bulk_we)      nv_img <= bulk_d;
      else if (byte_we) nv_img[byte_idx] <= byte_d;
      if (bulk_we || byte_we) remain <= CW'(BUSY_CYC);
      else if (remain != '0)  remain <= remain - 1'b1;
    end
  end

  assign busy = (remain != '0);

  // R8: no programming request may reach the array while it is busy
  p_no_commit_when_busy_r8: assert property (@(posedge clk) disable iff (!nv_init_n)
    (byte_we || bulk_we) |-> !busy);
  // R7: a bulk commit leaves the array busy
  p_busy_after_commit_r7: assert property (@(posedge clk) disable iff (!nv_init_n)
    bulk_we |=> busy);
  // R4: the stored image moves only on a commit request
  p_img_stable_r4: assert property (@(posedge clk) disable iff (!nv_init_n)
    (!byte_we && !bulk_we) |=> $stable(nv_img));
endmodule

// File: rtl/cfgs_regbank.sv
module cfgs_regbank import cfgs_pkg::*; #(
  parameter logic [4:0] RANGE_CODE = 5'h12
) (
  input  logic       clk,
  input  logic       rst_n,
  input  img_t       nv_img,
  input  logic       wr_en,
  input  logic [7:0] wr_ptr,
  input  logic [7:0] wr_d,
  input  logic [7:0] rd_ptr,
  output logic [7:0] rd_d,
  output img_t       work
);
  slot_t ws, rs;
  assign ws = slot_of(wr_ptr);
  assign rs = slot_of(rd_ptr);

  always_ff @(posedge clk) begin
    if (!rst_n) work <= nv_img;
    else if (wr_en && ws.hit) work[ws.idx] <= wr_d & byte_mask(ws.idx);
  end

  always_comb begin
    if (rd_ptr == PTR_RANGE) rd_d = {3'b0, RANGE_CODE};
    else if (rs.hit)         rd_d = work[rs.idx];
    else                     rd_d = 8'h00;
  end
endmodule

// File: rtl/clkgen_cfg_slave.sv
module clkgen_cfg_slave import cfgs_pkg::*; #(
  parameter int          NV_BUSY_CYCLES = 1000,
  parameter int          SYNC_STAGES    = 2,
  parameter logic [4:0]  RANGE_CODE     = 5'h12,
  parameter logic [9:0]  DAC_DEFAULT    = 10'h200,
  parameter logic [15:0] PRESC_DEFAULT  = 16'h0000,
  parameter logic [3:0]  IDENT_DEFAULT  = 4'h0
) (
  input  logic        clk,
  input  logic        nv_init_n,
  input  logic        rst_n,
  input  logic        scl_i,
  input  logic        sda_i,
  output logic        sda_oe,
  output logic [15:0] presc_word,
  output logic [9:0]  dac_code,
  output logic [4:0]  offset_code
);
  localparam img_t FACTORY = factory_image(PRESC_DEFAULT, DAC_DEFAULT, IDENT_DEFAULT, RANGE_CODE);

  logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
  img_t nv_img, work;
  logic nv_busy;
  logic [7:0] rd_d;

  bus_st_e    st;
  rx_kind_e   kind;
  logic [7:0] sh;
  logic [3:0] cnt;
  logic       rw;
  logic [7:0] ptr;

  // Named events for the checks and the commit paths.
  logic  byte_done, addr_hit, ack_now, data_wr, commit_req, nv_byte_we, wc;
  slot_t wslot;

  cfgs_line_sync #(.STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det));

  assign wc        = work[IX_IDENT][3];
  assign addr_hit  = (sh[7:1] == {DEV_ID, work[IX_IDENT][2:0]});
  assign byte_done = (st == ST_RX) && scl_fall && (cnt == 4'd8);
  assign ack_now   = !nv_busy && ((kind != K_ADDR) || addr_hit);
  assign data_wr   = byte_done && (kind == K_DATA) && ack_now;
  assign commit_req = byte_done && (kind == K_PTR) && ack_now && (sh == PTR_COMMIT);
  assign wslot     = slot_of(ptr);
  assign nv_byte_we = data_wr && wslot.hit && (!wc || ptr == PTR_IDENT);

  cfgs_nv_store #(.BUSY_CYC(NV_BUSY_CYCLES), .FACTORY(FACTORY)) nv_i (
    .clk(clk), .nv_init_n(nv_init_n),
    .byte_we(nv_byte_we), .byte_idx(wslot.idx), .byte_d(sh & byte_mask(wslot.idx)),
    .bulk_we(commit_req), .bulk_d(work),
    .nv_img(nv_img), .busy(nv_busy));

  cfgs_regbank #(.RANGE_CODE(RANGE_CODE)) regs_i (
    .clk(clk), .rst_n(rst_n), .nv_img(nv_img),
    .wr_en(data_wr), .wr_ptr(ptr), .wr_d(sh),
    .rd_ptr(ptr), .rd_d(rd_d), .work(work));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= ST_IDLE; kind <= K_ADDR; sh <= '0; cnt <= '0;
      rw <= 1'b0; ptr <= '0; sda_oe <= 1'b0;
    end else if (start_det) begin
      st <= ST_RX; kind <= K_ADDR; cnt <= '0; sda_oe <= 1'b0;
    end else if (stop_det) begin
      st <= ST_IDLE; sda_oe <= 1'b0;
    end else begin
      case (st)
        ST_RX: begin
          if (scl_rise && cnt < 4'd8) begin
            sh  <= {sh[6:0], sda_s};
            cnt <= cnt + 1'b1;
          end else if (byte_done) begin
            if (ack_now) begin
              sda_oe <= 1'b1;
              st     <= ST_RX_ACK;
              case (kind)
                K_ADDR:  rw  <= sh[0];
                K_PTR:   ptr <= sh;
                default: ptr <= ptr + 1'b1;
              endcase
            end else begin
              st <= ST_IDLE;
            end
          end
        end
        ST_RX_ACK: if (scl_fall) begin
          cnt <= '0;
          if (rw && kind == K_ADDR) begin
            st <= ST_TX; sh <= rd_d; sda_oe <= ~rd_d[7];
          end else begin
            st <= ST_RX; sda_oe <= 1'b0;
            kind <= (kind == K_ADDR) ? K_PTR : K_DATA;
          end
        end
        ST_TX: if (scl_fall) begin
          if (cnt == 4'd7) begin
            sda_oe <= 1'b0; st <= ST_TX_ACK; ptr <= ptr + 1'b1;
          end else begin
            sh <= {sh[6:0], 1'b0}; sda_oe <= ~sh[6]; cnt <= cnt + 1'b1;
          end
        end
        ST_TX_ACK: begin
          if (scl_rise && sda_s) st <= ST_IDLE;
          else if (scl_fall) begin
            st <= ST_TX; sh <= rd_d; sda_oe <= ~rd_d[7]; cnt <= '0;
          end
        end
        default: ;
      endcase
    end
  end

  assign presc_word  = {work[0], work[1]};
  assign dac_code    = dac_code_of(work[2], work[3]);
  assign offset_code = work[5][4:0];

  // R9: the slave starts pulling the line low only while the clock is low
  p_drive_only_scl_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !scl_s);
  // R1: a STOP leaves the data line released
  p_stop_release_r1: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> !sda_oe);
endmodule

// File: tb/clkgen_cfg_slave_tb_top.sv
`timescale 1ns/1ps
module clkgen_cfg_slave_tb_top;
  localparam int H = 10;
  localparam int BUSY = 600;
  localparam logic [4:0] RNG = 5'h12;

  logic clk = 0, nv_init_n = 0, rst_n = 0, scl_m = 1, sda_m = 1;
  logic sda_oe, sda_line;
  logic [15:0] presc_word;
  logic [9:0] dac_code;
  logic [4:0] offset_code;
  int checks = 0, fails = 0;
  logic [7:0] work_m [6];
  logic [7:0] nv_m [6];
  logic [7:0] wbuf [4];
  logic [7:0] rbuf [4];
  logic abuf [8];

  always #10 clk = ~clk;
  assign sda_line = sda_m & ~sda_oe;

  clkgen_cfg_slave #(.NV_BUSY_CYCLES(BUSY), .RANGE_CODE(RNG)) dut_i (
    .clk(clk), .nv_init_n(nv_init_n), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
    .sda_oe(sda_oe), .presc_word(presc_word), .dac_code(dac_code), .offset_code(offset_code));

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic wait_c(input int n); repeat (n) @(negedge clk); endtask

  // Bench view of the register map.
  function automatic int ix_of(input logic [7:0] p);
    case (p)
      8'h02: return 0; 8'h03: return 1; 8'h08: return 2;
      8'h09: return 3; 8'h0D: return 4; 8'h0E: return 5;
      default: return -1;
    endcase
  endfunction
  function automatic logic [7:0] keep_bits(input int ix);
    if (ix == 3) return 8'hC0;
    if (ix == 4) return 8'h0F;
    if (ix == 5) return 8'h1F;
    return 8'hFF;
  endfunction
  function automatic logic [7:0] exp_rd(input logic [7:0] p);
    int ix = ix_of(p);
    if (p == 8'h37) return {3'b0, RNG};
    if (ix < 0) return 8'h00;
    return work_m[ix];
  endfunction
  function automatic logic [6:0] dev_addr();
    return {4'b1011, work_m[4][2:0]};
  endfunction
  task automatic mdl_write(input logic [7:0] p, input logic [7:0] d);
    int ix = ix_of(p);
    if (ix >= 0) begin
      logic old_wc = work_m[4][3];
      work_m[ix] = d & keep_bits(ix);
      if (!old_wc || p == 8'h0D) nv_m[ix] = work_m[ix];
    end
  endtask

  task automatic i2c_start;
    sda_m = 1; wait_c(H); scl_m = 1; wait_c(H); sda_m = 0; wait_c(H); scl_m = 0; wait_c(2);
  endtask
  task automatic i2c_stop;
    sda_m = 0; wait_c(H); scl_m = 1; wait_c(H); sda_m = 1; wait_c(H);
  endtask
  task automatic send_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; wait_c(H); scl_m = 1; wait_c(H); scl_m = 0; wait_c(2);
    end
    sda_m = 1; wait_c(H); scl_m = 1; wait_c(H/2); ack = (sda_line == 1'b0);
    wait_c(H/2); scl_m = 0; wait_c(2);
  endtask
  task automatic recv_byte(input logic mack, output logic [7:0] b);
    sda_m = 1;
    for (int i = 7; i >= 0; i--) begin
      wait_c(H); scl_m = 1; wait_c(H/2); b[i] = sda_line; wait_c(H/2); scl_m = 0; wait_c(2);
    end
    sda_m = !mack; wait_c(H); scl_m = 1; wait_c(H); scl_m = 0; wait_c(2); sda_m = 1;
  endtask

  task automatic wr_txn(input logic [6:0] a, input logic [7:0] p, input int n);
    i2c_start;
    send_byte({a, 1'b0}, abuf[0]);
    send_byte(p, abuf[1]);
    for (int k = 0; k < n; k++) send_byte(wbuf[k], abuf[2+k]);
    i2c_stop;
  endtask
  task automatic rd_txn(input logic [6:0] a, input logic [7:0] p, input int n);
    i2c_start;
    send_byte({a, 1'b0}, abuf[0]);
    send_byte(p, abuf[1]);
    i2c_start;
    send_byte({a, 1'b1}, abuf[2]);
    for (int k = 0; k < n; k++) recv_byte(k < n-1, rbuf[k]);
    i2c_stop;
  endtask
  task automatic probe(input logic [6:0] a, output logic ack);
    i2c_start; send_byte({a, 1'b0}, ack); i2c_stop;
  endtask
  task automatic power_cycle;
    rst_n = 0; wait_c(4); rst_n = 1; wait_c(4);
    for (int i = 0; i < 6; i++) work_m[i] = nv_m[i];
  endtask
  task automatic check_outs(input string tag);
    check({tag, " presc"}, presc_word, {work_m[0], work_m[1]});
    check({tag, " dac"}, dac_code, {work_m[2], work_m[3][7:6]});
    check({tag, " offset"}, offset_code, work_m[5][4:0]);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog act=%0d exp=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic ack;
    void'($urandom(32'd20240611));
    nv_m = '{8'h00, 8'h00, 8'h80, 8'h00, 8'h00, {3'b0, RNG}};
    work_m = nv_m;
    wait_c(5); nv_init_n = 1; rst_n = 1; wait_c(5);

    // R10 R12: factory image after init
    check_outs("R10 reset");
    check("R10 sda released", sda_oe, 0);
    rd_txn(dev_addr(), 8'h08, 2);
    check("R9 read dac hi", rbuf[0], 8'h80);
    check("R9 read dac lo", rbuf[1], 8'h00);
    check("R9 released after nack", sda_oe, 0);
    rd_txn(dev_addr(), 8'h37, 1);
    check("R11 range reads factory", rbuf[0], {3'b0, RNG});
    rd_txn(dev_addr(), 8'h0E, 1);
    check("R10 offset default", rbuf[0], {3'b0, RNG});

    // R2: foreign addresses
    probe(7'b1010001, ack); check("R2 foreign id nack", ack, 0);
    probe(7'b1011001, ack); check("R2 wrong select nack", ack, 0);
    check("R2 line released", sda_oe, 0);

    // R5: write-through of a single byte
    wbuf[0] = 8'h5A; wr_txn(dev_addr(), 8'h08, 1); mdl_write(8'h08, 8'h5A);
    check("R5 data ack", abuf[2], 1);
    wait_c(BUSY + 100);
    power_cycle; check_outs("R5 kept after power cycle");

    // R8: second byte arrives while busy
    wbuf[0] = 8'h11; wbuf[1] = 8'h22; wr_txn(dev_addr(), 8'h02, 2); mdl_write(8'h02, 8'h11);
    check("R8 first byte ack", abuf[2], 1);
    check("R8 busy byte nack", abuf[3], 0);
    check_outs("R8 busy byte dropped");
    wait_c(BUSY + 100);

    // R8: address refused while busy
    wbuf[0] = 8'h07; wr_txn(dev_addr(), 8'h0E, 1); mdl_write(8'h0E, 8'h07);
    probe(dev_addr(), ack); check("R8 address nack while busy", ack, 0);
    wait_c(BUSY + 100);
    probe(dev_addr(), ack); check("R8 address ack after busy", ack, 1);

    // switch to shadow mode
    wbuf[0] = 8'h08; wr_txn(dev_addr(), 8'h0D, 1); mdl_write(8'h0D, 8'h08);
    wait_c(BUSY + 100);

    // R3 R4: multi-byte shadow write, masking and unmapped location
    wbuf[0] = 8'hC3; wbuf[1] = 8'hFF; wbuf[2] = 8'h0A;
    wr_txn(dev_addr(), 8'h08, 3);
    for (int k = 0; k < 3; k++) mdl_write(8'(8'h08 + k), wbuf[k]);
    check("R3 ack byte 3", abuf[4], 1);
    check("R3 dac code", dac_code, 10'h30F);
    rd_txn(dev_addr(), 8'h08, 3);
    check("R3 read hi", rbuf[0], 8'hC3);
    check("R3 read lo masked", rbuf[1], 8'hC0);
    check("R3 unmapped reads 0", rbuf[2], 8'h00);
    power_cycle;
    check("R4 shadow reverted", dac_code, {8'h5A, 2'b00});

    // R11: read-only location
    wbuf[0] = 8'h05; wr_txn(dev_addr(), 8'h37, 1);
    check("R11 write acked", abuf[2], 1);
    rd_txn(dev_addr(), 8'h37, 1);
    check("R11 write ignored", rbuf[0], {3'b0, RNG});

    // R6: identity commits even in shadow mode
    wbuf[0] = 8'h0B; wr_txn(dev_addr(), 8'h0D, 1); mdl_write(8'h0D, 8'h0B);
    wait_c(BUSY + 100);
    probe(7'b1011000, ack); check("R6 old address refused", ack, 0);
    power_cycle;
    rd_txn(dev_addr(), 8'h0D, 1);
    check("R6 identity survived", rbuf[0], 8'h0B);

    // R7: bulk commit
    wbuf[0] = 8'h33; wbuf[1] = 8'h40; wr_txn(dev_addr(), 8'h08, 2);
    mdl_write(8'h08, 8'h33); mdl_write(8'h09, 8'h40);
    wr_txn(dev_addr(), 8'h3F, 0);
    check("R7 command acked", abuf[1], 1);
    for (int i = 0; i < 6; i++) nv_m[i] = work_m[i];
    probe(dev_addr(), ack); check("R8 nack during bulk commit", ack, 0);
    wait_c(BUSY + 100);
    power_cycle;
    check("R7 committed code", dac_code, 10'h0CD);

    // R3 R9 R12: random shadow writes with readback
    for (int it = 0; it < 24; it++) begin
      logic [7:0] p;
      int n = 1 + ($urandom % 3);
      case ($urandom % 8)
        0: p = 8'h02; 1: p = 8'h03; 2: p = 8'h08; 3: p = 8'h09;
        4: p = 8'h0E; 5: p = 8'h37;
        default: p = 8'($urandom % 64);
      endcase
      if ((p >= 8'h0B && p <= 8'h0D) || p == 8'h3F) p = 8'h20;
      for (int k = 0; k < n; k++) wbuf[k] = 8'($urandom);
      wr_txn(dev_addr(), p, n);
      for (int k = 0; k < n; k++) mdl_write(8'(p + k), wbuf[k]);
      check("R3 random last ack", abuf[1+n], 1);
      rd_txn(dev_addr(), p, n);
      for (int k = 0; k < n; k++) check("R9 random readback", rbuf[k], exp_rd(8'(p + k)));
      check_outs("R12 random outputs");
      if (it % 6 == 5) begin
        wr_txn(dev_addr(), 8'h3F, 0);
        for (int i = 0; i < 6; i++) nv_m[i] = work_m[i];
        wait_c(BUSY + 100);
        power_cycle;
        check_outs("R7 random commit kept");
      end
    end

    // R1: STOP releases and a fresh START is served
    check("R1 released after stop", sda_oe, 0);
    probe(dev_addr(), ack); check("R1 new transfer acked", ack, 1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule